// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block drives a peripheral, such as an analog-to-digital converter, over a three-wire synchronous link with a framing strobe. A one-cycle write strobe carries a byte and starts a frame. The frame opens with one bit period in which the framing strobe is high. Sixteen data bit periods follow. In the first eight of them the byte is sent out most significant bit first. During all sixteen the incoming line is captured, giving a 16-bit word. The serial clock toggles only while a frame is in progress and is held low at all other times.

A 2-bit rate code selects the length of a bit period. The code is captured when the frame starts. At completion the captured word is moved to the receive output and a completion interrupt is raised. The interrupt is cleared when the word is read or when the next frame starts. A separate sample clock runs at twice the bit rate. It can be switched on and off on its own, independently of any frame.

Top module: `ssp_master`

## Requirements
- R1: After reset, busy, done_irq, sclk, sync, mosi and smp_clk are 0 and rx_data is 0.
- R2: A tx_wr pulse while busy is 0 sets busy from the next cycle. busy then stays 1 for exactly 34*H cycles, where the half period H is 2 << rate_sel (codes 0,1,2,3 give H = 2,4,8,16 clock cycles), using rate_sel as sampled with tx_wr.
- R3: sclk is 0 whenever busy is 0. A frame has 17 bit periods, and in each sclk is low for H cycles and then high for H cycles.
- R4: sync is 1 for exactly the first bit period of a frame (2*H cycles) and 0 otherwise.
- R5: mosi carries tx_data bit 7 down to bit 0 in bit periods 1 through 8, one bit per period. mosi is 0 in bit period 0, in periods 9 to 16, and while idle.
- R6: miso is sampled at the rising sclk edge of bit periods 1 to 16. The first sample lands in rx_data[15] and the last in rx_data[0], and miso during the sync period is ignored. rx_data changes only when a frame completes and holds its value during a frame.
- R7: done_irq rises in the cycle busy falls. It is cleared by an rx_rd pulse while idle or by the start of a new frame. If rx_rd coincides with completion, the completion wins and done_irq stays 1.
- R8: tx_wr while busy is 1 is ignored: the running frame keeps its data, length and rate.
- R9: While smp_en is 1, smp_clk is a square wave that changes level every H/2 cycles, so its period is H (twice the bit rate). While smp_en is 0, smp_clk is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | One-cycle strobe: load tx_data and start a frame |
| tx_data | input | 8 | Byte to send |
| rate_sel | input | 2 | Bit-rate code, half period H = 2 << rate_sel |
| smp_en | input | 1 | Enables the double-rate sample clock |
| rx_rd | input | 1 | One-cycle strobe: the received word was read, clears done_irq |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Frame in progress |
| done_irq | output | 1 | Completion interrupt |
| rx_data | output | 16 | Last received word |
| sclk | output | 1 | Serial clock, low when idle |
| sync | output | 1 | Framing strobe, high for the first bit period |
| mosi | output | 1 | Serial data to the peripheral |
| smp_clk | output | 1 | Sample clock at twice the bit rate |

## Verification
The interrupt has two events that can land on the same clock edge: frame completion sets it and a read strobe clears it. The bench counts the cycles of a frame from its length 34*H and places rx_rd on exactly the completing edge. It then expects done_irq to read 1 afterwards, and to read 0 after a later rx_rd on its own. In the same way, a start strobe issued while done_irq is still set must clear it in the first cycle of the new frame.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int TX_W    = 8;
    localparam int RX_W    = 16;
    localparam int RATE_W  = 2;
    localparam int HALF_W  = 6;
    localparam int MIN_HALF = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ssp_state_e;

    typedef struct packed {
        logic sclk;
        logic sync;
        logic mosi;
    } ssp_pins_t;

    function automatic logic [HALF_W-1:0] half_of(input logic [RATE_W-1:0] code);
        return HALF_W'(MIN_HALF) << code;
    endfunction
endpackage

// File: rtl/ssp_smpclk.sv
module ssp_smpclk #(
    parameter int HW = ssp_pkg::HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [HW-1:0] quarter,
    output logic          smp
);
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            smp <= 1'b0;
        end else if (cnt >= quarter - 1'b1) begin
            cnt <= '0;
            smp <= ~smp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_frame.sv
module ssp_frame
    import ssp_pkg::*;
#(
    parameter int TW = TX_W,
    parameter int RW = RX_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [HW-1:0] half,
    input  logic [TW-1:0] tx_data,
    input  logic          miso,
    input  logic          rx_rd,
    output logic          busy,
    output ssp_pins_t     pins,
    output logic [RW-1:0] rx_word,
    output logic          irq
);
    localparam int IDX_W = $clog2(RW + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RW);
    localparam logic [IDX_W-1:0] TX_LAST  = IDX_W'(TW);

    ssp_state_e     state;
    logic [HW-1:0]  half_q;
    logic [HW-1:0]  hcnt;
    logic           phase;
    logic [IDX_W-1:0] idx;
    logic [TW-1:0]  txsh;
    logic [RW-1:0]  rxsh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            half_q  <= '0;
            hcnt    <= '0;
            phase   <= 1'b0;
            idx     <= '0;
            txsh    <= '0;
            rxsh    <= '0;
            rx_word <= '0;
            irq     <= 1'b0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state  <= ST_RUN;
                half_q <= half;
                hcnt   <= '0;
                phase  <= 1'b0;
                idx    <= '0;
                txsh   <= tx_data;
                irq    <= 1'b0;
            end else if (rx_rd) begin
                irq <= 1'b0;
            end
        end else begin
            if (rx_rd) irq <= 1'b0;
            if (hcnt == half_q - 1'b1) begin
                hcnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                    if (idx != '0) rxsh <= {rxsh[RW-2:0], miso};
                end else begin
                    phase <= 1'b0;
                    if (idx != '0) txsh <= {txsh[TW-2:0], 1'b0};
                    if (idx == LAST_IDX) begin
                        state   <= ST_IDLE;
                        rx_word <= rxsh;
                        irq     <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state == ST_RUN);
        pins.sclk = busy && phase;
        pins.sync = busy && (idx == '0);
        pins.mosi = busy && (idx != '0) && (idx <= TX_LAST) && txsh[TW-1];
    end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
    import ssp_pkg::*;
#(
    parameter int TW = TX_W,
    parameter int RW = RX_W,
    parameter int RSW = RATE_W,
    parameter int HW = HALF_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tx_wr,
    input  logic [TW-1:0]  tx_data,
    input  logic [RSW-1:0] rate_sel,
    input  logic           smp_en,
    input  logic           rx_rd,
    input  logic           miso,
    output logic           busy,
    output logic           done_irq,
    output logic [RW-1:0]  rx_data,
    output logic           sclk,
    output logic           sync,
    output logic           mosi,
    output logic           smp_clk
);
    logic [HW-1:0] half;
    logic          start;
    ssp_pins_t     pins;

    assign half  = HW'(MIN_HALF) << rate_sel;
    assign start = tx_wr && !busy;

    ssp_frame #(.TW(TW), .RW(RW), .HW(HW)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .half    (half),
        .tx_data (tx_data),
        .miso    (miso),
        .rx_rd   (rx_rd),
        .busy    (busy),
        .pins    (pins),
        .rx_word (rx_data),
        .irq     (done_irq)
    );

    ssp_smpclk #(.HW(HW)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .en      (smp_en),
        .quarter (half >> 1),
        .smp     (smp_clk)
    );

    assign sclk = pins.sclk;
    assign sync = pins.sync;
    assign mosi = pins.mosi;
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk #(
    parameter int RW = ssp_pkg::RX_W
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_wr,
    input logic          rx_rd,
    input logic          smp_en,
    input logic          busy,
    input logic          done_irq,
    input logic [RW-1:0] rx_data,
    input logic          sclk,
    input logic          sync,
    input logic          mosi,
    input logic          smp_clk
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && !busy) |=> (busy && sync));

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && !mosi));

    p_sync_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        sync |-> busy);

    p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rx_data));

    p_irq_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !busy && !tx_wr) |=> !done_irq);

    p_irq_finish_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_irq);

    p_smp_off_r9: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> !smp_clk);
endmodule

bind ssp_master ssp_master_chk #(.RW(RW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_wr    (tx_wr),
    .rx_rd    (rx_rd),
    .smp_en   (smp_en),
    .busy     (busy),
    .done_irq (done_irq),
    .rx_data  (rx_data),
    .sclk     (sclk),
    .sync     (sync),
    .mosi     (mosi),
    .smp_clk  (smp_clk)
);

// File: tb/sim_ssp_master.sv
`timescale 1ns/1ps
module sim_ssp_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = '0;
    logic [1:0]  rate_sel = '0;
    logic        smp_en = 1'b0;
    logic        rx_rd = 1'b0;
    logic        miso = 1'b0;
    logic        busy, done_irq, sclk, sync, mosi, smp_clk;
    logic [15:0] rx_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ssp_master u0 (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data),
        .rate_sel(rate_sel), .smp_en(smp_en), .rx_rd(rx_rd), .miso(miso),
        .busy(busy), .done_irq(done_irq), .rx_data(rx_data), .sclk(sclk),
        .sync(sync), .mosi(mosi), .smp_clk(smp_clk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int half_of(input int r);
        return 2 << r;
    endfunction

    function automatic bit exp_sclk(input int c, input int h);
        return (c % (2 * h)) >= h;
    endfunction

    function automatic bit exp_mosi(input int c, input int h, input logic [7:0] tx);
        int p = c / (2 * h);
        if (p >= 1 && p <= 8) return tx[8 - p];
        return 1'b0;
    endfunction

    function automatic bit miso_for(input int c, input int h, input logic [15:0] pat);
        int p = c / (2 * h);
        if (p >= 1 && p <= 16) return pat[16 - p];
        return ~pat[15];
    endfunction

    // Called at a falling edge with the bench idle.
    task automatic run_xfer(input logic [7:0] tx, input logic [15:0] pat, input int r,
                            input bit mid_wr, input bit coinc);
        int h = half_of(r);
        int n = 34 * h;
        int e_busy = 0, e_sclk = 0, e_sync = 0, e_mosi = 0, e_irq = 0, e_rx = 0;
        logic [15:0] rx_before = rx_data;
        rate_sel = 2'(r);
        tx_data  = tx;
        tx_wr    = 1'b1;
        miso     = ~pat[15];
        @(negedge clk);
        tx_wr = 1'b0;
        for (int c = 0; c < n; c++) begin
            if (busy !== 1'b1) e_busy++;
            if (sclk !== exp_sclk(c, h)) e_sclk++;
            if (sync !== (c < 2 * h)) e_sync++;
            if (mosi !== exp_mosi(c, h, tx)) e_mosi++;
            if (done_irq !== 1'b0) e_irq++;
            if (rx_data !== rx_before) e_rx++;
            tx_wr = 1'b0;
            rate_sel = 2'(r);
            tx_data = tx;
            if (mid_wr && (c == 5 * h || c == 20 * h)) begin
                tx_wr = 1'b1;          // R8: must be ignored
                tx_data = ~tx;
                rate_sel = 2'(r ^ 1);
            end
            rx_rd = coinc && (c == n - 1);
            miso = miso_for(c + 1, h, pat);
            @(negedge clk);
        end
        tx_wr = 1'b0;
        rx_rd = 1'b0;
        chk(e_busy == 0, "R2", "busy low inside frame", e_busy, 0);
        chk(busy === 1'b0, "R2", "busy after 34*H cycles", busy, 0);
        chk(e_sclk == 0, "R3", "sclk waveform errors", e_sclk, 0);
        chk(e_sync == 0, "R4", "sync waveform errors", e_sync, 0);
        chk(e_mosi == 0, "R5", "mosi bit errors", e_mosi, 0);
        chk(e_irq == 0, "R7", "irq not cleared by start", e_irq, 0);
        chk(e_rx == 0, "R6", "rx_data moved during frame", e_rx, 0);
        chk(rx_data === pat, "R6", "received word", rx_data, pat);
        chk(done_irq === 1'b1, "R7", "irq at completion", done_irq, 1);
        if (mid_wr) chk(busy === 1'b0 && e_mosi == 0, "R8", "write while busy ignored", busy, 0);
        if (coinc) chk(done_irq === 1'b1, "R7", "completion beats same-cycle read", done_irq, 1);
    endtask

    task automatic idle_check(input int cycles);
        int e = 0;
        for (int i = 0; i < cycles; i++) begin
            if (sclk !== 1'b0 || mosi !== 1'b0 || sync !== 1'b0) e++;
            @(negedge clk);
        end
        chk(e == 0, "R3", "serial pins idle", e, 0);
    endtask

    task automatic smp_test(input int r);
        int q = half_of(r) / 2;
        int last = -1, bad = 0, edges = 0, e_off = 0;
        logic prev;
        rate_sel = 2'(r);
        smp_en = 1'b1;
        repeat (3) @(negedge clk);
        prev = smp_clk;
        for (int c = 0; c < 8 * half_of(r); c++) begin
            @(negedge clk);
            if (smp_clk !== prev) begin
                if (last >= 0 && (c - last) != q) bad++;
                last = c;
                edges++;
                prev = smp_clk;
            end
        end
        chk(bad == 0 && edges >= 8, "R9", "sample clock half period", bad, 0);
        smp_en = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 20; c++) begin
            if (smp_clk !== 1'b0) e_off++;
            @(negedge clk);
        end
        chk(e_off == 0, "R9", "sample clock off", e_off, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy === 0 && done_irq === 0 && sclk === 0 && sync === 0 && mosi === 0,
            "R1", "control outputs after reset", {busy, done_irq, sclk, sync, mosi}, 0);
        chk(rx_data === 16'h0 && smp_clk === 1'b0, "R1", "data and sample clock after reset",
            rx_data, 0);
        idle_check(6);

        run_xfer(8'hA5, 16'h8001, 0, 1'b0, 1'b0);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(done_irq === 1'b0, "R7", "read clears irq", done_irq, 0);
        chk(rx_data === 16'h8001, "R6", "word held after read", rx_data, 16'h8001);
        idle_check(5);

        run_xfer(8'h80, 16'hFFFF, 3, 1'b1, 1'b0);
        run_xfer(8'h01, 16'h0000, 1, 1'b0, 1'b1);
        @(negedge clk);
        chk(done_irq === 1'b1, "R7", "irq stays set without read", done_irq, 1);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(done_irq === 1'b0, "R7", "later read clears irq", done_irq, 0);
        run_xfer(8'hFF, 16'h5AC3, 2, 1'b1, 1'b0);

        for (int k = 0; k < 10; k++) begin
            logic [7:0]  tx = 8'($urandom);
            logic [15:0] pt = 16'($urandom);
            int r = int'($urandom % 3);
            run_xfer(tx, pt, r, bit'($urandom % 2), bit'($urandom % 2));
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        smp_test(0);
        smp_test(1);
        smp_test(3);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule